// File: doc/BRIEF.md
# Bang-Bang Proportional-Integral Loop Filter

This block sits between a decimated bang-bang phase detector and a digitally controlled oscillator built from a switched capacitor bank, inside an all-digital clock recovery loop. Each filter clock carries at most one binary phase decision. A qualifier marks whether the decision is present, and two flags say whether the recovered clock sampled late or early. The filter turns that decision into a signed error of +1, -1 or 0. The error is scaled by a programmable proportional gain and is also accumulated into a fractional integrator whose gain is a power of two set by a shift amount.

The oscillator word is a registered sum of three terms: a fixed calibration offset that puts the oscillator near the line rate, the integer part of the integrator, and the proportional kick. The sum is limited to the range of the capacitor bank. Between bursts no decision arrives. The integrator then keeps its exact value, so the frequency does not wander while no reference is present, and the word settles to the offset plus the held integral.

Top module: `bb_pi_loop_filter`

## Requirements
- R1: While reset is low, `dco_word` is 0 and the integrator is cleared to 0.
- R2: With `pd_valid` high, the error is +1 when only `pd_late` is set and -1 when only `pd_early` is set. When both flags or neither flag are set, the error is 0: the integrator does not move and the word carries no proportional term.
- R3: The proportional term equals `kp_gain` (unsigned, 0 to 15) times the error. It is present only in the word registered for the cycle that sampled the decision.
- R4: The integrator holds 9 fractional bits. A +1 or -1 error adds or subtracts 2^(9-s), where s is `ki_shift`, so the integral gain is 2^-s. Values of s above 9 behave as 9.
- R5: While `pd_valid` is low, the integrator is unchanged. With `cal_offset` constant, `dco_word` stays the same from the second idle cycle onward.
- R6: The integrator saturates at +131071 and -131072, counted in units of 2^-9, instead of wrapping. Its integer part therefore spans -256 to +255.
- R7: `dco_word` = `cal_offset` + floor(integrator / 512) + proportional term, clamped to the range 0 to 255.
- R8: `dco_word` changes on the same rising edge that samples the decision and gain inputs. There is one register from input to output.
- R9: A change of `cal_offset` reaches `dco_word` on the next rising edge, even while `pd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock at the decimated rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_valid | input | 1 | A phase decision is present this cycle |
| pd_early | input | 1 | Recovered clock leads the data |
| pd_late | input | 1 | Recovered clock lags the data |
| kp_gain | input | 4 | Proportional gain, unsigned |
| ki_shift | input | 4 | Integral gain exponent; gain is 2^-ki_shift |
| cal_offset | input | 8 | One-time calibration centre of the oscillator word |
| dco_word | output | 8 | Capacitor-bank control word |

## Verification
The word depends on the decision, gains and offset sampled at one rising edge, and it is due right after that edge. The bench drives inputs on falling edges. At every following falling edge it compares the port against a behavioural model that has been advanced once for each rising edge. The proportional kick therefore has to show up in exactly one compared cycle and be gone in the next. The hold behaviour in a gap is checked over long idle runs, and the saturation and clamp limits are reached by driving hundreds of decisions of one sign at the largest integral gain. Each of these compares falls on the cycle where the model puts the result.

// File: rtl/lf_pkg.sv
package lf_pkg;
  // Decoded direction of one decimated phase decision.
  typedef enum logic [1:0] {
    PE_NONE  = 2'b00,
    PE_LATE  = 2'b01,
    PE_EARLY = 2'b10
  } pe_dir_t;
endpackage

// File: rtl/lf_phase_decode.sv
module lf_phase_decode
  import lf_pkg::*;
(
  input  logic    valid,
  input  logic    early,
  input  logic    late,
  output pe_dir_t dir
);
  // Conflicting or absent flags carry no phase information.
  always_comb begin
    dir = PE_NONE;
    if (valid) begin
      if (late && !early)      dir = PE_LATE;
      else if (early && !late) dir = PE_EARLY;
    end
  end
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator
  import lf_pkg::*;
#(
  parameter int ACC_W = 18,
  parameter int FRAC  = 9,
  parameter int SH_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pe_dir_t                dir,
  input  logic [SH_W-1:0]        ki_shift,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-FRAC-1:0] int_d
);
  localparam int SHAMT_W = $clog2(FRAC + 1);
  localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [SHAMT_W-1:0]      eff_sh;
  logic [ACC_W:0]          step;
  logic [ACC_W:0]          wide;
  logic [ACC_W:0]          sum;
  logic signed [ACC_W-1:0] acc_d;
  logic                    acc_en;

  // Shift amounts beyond the fractional width fall back to the smallest gain.
  generate
    if ((2 ** SH_W) - 1 > FRAC) begin : g_sh_clamp
      always_comb begin
        if (ki_shift > SH_W'(FRAC)) eff_sh = SHAMT_W'(FRAC);
        else                        eff_sh = ki_shift[SHAMT_W-1:0];
      end
    end else begin : g_sh_pass
      always_comb eff_sh = SHAMT_W'(ki_shift);
    end
  endgenerate

  always_comb begin
    acc_en = (dir != PE_NONE);
    step   = ONE << (SHAMT_W'(FRAC) - eff_sh);
    wide   = {acc_q[ACC_W-1], acc_q};
    if (dir == PE_EARLY) sum = wide - step;
    else                 sum = wide + step;
    acc_d = acc_q;
    if (acc_en) begin
      if (sum[ACC_W] != sum[ACC_W-1]) begin
        acc_d = (dir == PE_EARLY) ? ACC_MIN : ACC_MAX;
      end else begin
        acc_d = sum[ACC_W-1:0];
      end
    end
    int_d = acc_d[ACC_W-1:FRAC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/lf_ctrl_sum.sv
module lf_ctrl_sum
  import lf_pkg::*;
#(
  parameter int CW   = 8,
  parameter int IW   = 9,
  parameter int KP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pe_dir_t              dir,
  input  logic [KP_W-1:0]      kp,
  input  logic [CW-1:0]        cal,
  input  logic signed [IW-1:0] int_d,
  output logic [CW-1:0]        word_q
);
  localparam int SW = ((IW > CW) ? IW : CW) + KP_W + 3;
  localparam logic signed [SW-1:0] WORD_MAX = SW'((2 ** CW) - 1);

  logic signed [SW-1:0] cal_ext;
  logic signed [SW-1:0] int_ext;
  logic signed [SW-1:0] kp_ext;
  logic signed [SW-1:0] prop;
  logic signed [SW-1:0] total;
  logic [CW-1:0]        word_d;
  logic                 word_en;

  always_comb begin
    cal_ext = {{(SW-CW){1'b0}}, cal};
    int_ext = {{(SW-IW){int_d[IW-1]}}, int_d};
    kp_ext  = {{(SW-KP_W){1'b0}}, kp};
    unique case (dir)
      PE_LATE:  prop = kp_ext;
      PE_EARLY: prop = -kp_ext;
      default:  prop = '0;
    endcase
    total = cal_ext + int_ext + prop;
    if (total < 0)             word_d = '0;
    else if (total > WORD_MAX) word_d = {CW{1'b1}};
    else                       word_d = total[CW-1:0];
    word_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/bb_pi_loop_filter.sv
module bb_pi_loop_filter
  import lf_pkg::*;
#(
  parameter int CW   = 8,
  parameter int FRAC = 9,
  parameter int KP_W = 4,
  parameter int KI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_valid,
  input  logic            pd_early,
  input  logic            pd_late,
  input  logic [KP_W-1:0] kp_gain,
  input  logic [KI_W-1:0] ki_shift,
  input  logic [CW-1:0]   cal_offset,
  output logic [CW-1:0]   dco_word
);
  localparam int IW    = CW + 1;
  localparam int ACC_W = IW + FRAC;

  pe_dir_t                 dir;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [IW-1:0]    int_d;

  lf_phase_decode u_dec (
    .valid (pd_valid),
    .early (pd_early),
    .late  (pd_late),
    .dir   (dir)
  );

  lf_integrator #(.ACC_W(ACC_W), .FRAC(FRAC), .SH_W(KI_W)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir      (dir),
    .ki_shift (ki_shift),
    .acc_q    (acc_q),
    .int_d    (int_d)
  );

  lf_ctrl_sum #(.CW(CW), .IW(IW), .KP_W(KP_W)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir    (dir),
    .kp     (kp_gain),
    .cal    (cal_offset),
    .int_d  (int_d),
    .word_q (dco_word)
  );
endmodule

// File: rtl/bb_pi_loop_filter_checker.sv
module bb_pi_loop_filter_checker #(
  parameter int CW    = 8,
  parameter int ACC_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pd_valid,
  input logic                    pd_early,
  input logic                    pd_late,
  input logic [CW-1:0]           cal_offset,
  input logic [CW-1:0]           dco_word,
  input logic signed [ACC_W-1:0] acc_q
);
  logic          prev_idle;
  logic [CW-1:0] prev_cal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idle <= 1'b0;
      prev_cal  <= '0;
    end else begin
      prev_idle <= !pd_valid;
      prev_cal  <= cal_offset;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (dco_word == '0 && acc_q == '0)
        else $error("reset state not clear");
    end
  end

  assert_tie_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_early && pd_late) |=> $stable(acc_q));

  assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_valid |=> $stable(acc_q));

  assert_word_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_valid && prev_idle && cal_offset == prev_cal) |=> $stable(dco_word));

  assert_up_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_late && !pd_early) |=> (acc_q >= $past(acc_q)));

  assert_dn_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_early && !pd_late) |=> (acc_q <= $past(acc_q)));
endmodule

bind bb_pi_loop_filter bb_pi_loop_filter_checker #(.CW(CW), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_valid   (pd_valid),
  .pd_early   (pd_early),
  .pd_late    (pd_late),
  .cal_offset (cal_offset),
  .dco_word   (dco_word),
  .acc_q      (acc_q)
);

// File: tb/bb_pi_loop_filter_test.sv
`timescale 1ns/1ps
module bb_pi_loop_filter_test;
  localparam int ACC_MAX_M = 131071;
  localparam int ACC_MIN_M = -131072;
  localparam int WORD_MAX_M = 255;

  logic       clk;
  logic       rst_n;
  logic       pd_valid, pd_early, pd_late;
  logic [3:0] kp_gain, ki_shift;
  logic [7:0] cal_offset;
  logic [7:0] dco_word;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    acc_m    = 0;
  int    exp_word = 0;
  int    kp_v = 0, ki_v = 9, cal_v = 0;
  string tag = "R1";
  bit    done = 0;

  bb_pi_loop_filter uut (
    .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid), .pd_early(pd_early),
    .pd_late(pd_late), .kp_gain(kp_gain), .ki_shift(ki_shift),
    .cal_offset(cal_offset), .dco_word(dco_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dco_word=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One filter cycle: compare the word due from the last edge, then drive and model the next.
  task automatic cyc(input bit v, input bit e, input bit l);
    int err, sh, step, s;
    @(negedge clk);
    check(tag, int'(dco_word), exp_word);
    pd_valid = v; pd_early = e; pd_late = l;
    kp_gain = 4'(kp_v); ki_shift = 4'(ki_v); cal_offset = 8'(cal_v);
    err = 0;
    if (v && l && !e) err = 1;
    if (v && e && !l) err = -1;
    sh = (ki_v > 9) ? 9 : ki_v;
    step = 1 << (9 - sh);
    if (err == 1)  acc_m = (acc_m + step > ACC_MAX_M) ? ACC_MAX_M : acc_m + step;
    if (err == -1) acc_m = (acc_m - step < ACC_MIN_M) ? ACC_MIN_M : acc_m - step;
    s = cal_v + (acc_m >>> 9) + kp_v * err;
    exp_word = (s < 0) ? 0 : (s > WORD_MAX_M) ? WORD_MAX_M : s;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    pd_valid = 0; pd_early = 0; pd_late = 0;
    kp_gain = 0; ki_shift = 9; cal_offset = 0;
    #1 rst_n = 1'b0;
    // R1: reset state on the port
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", int'(dco_word), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R9: offset appears on the next edge with no decisions
    tag = "R9"; cal_v = 100;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    // R8/R3: a single late decision gives a one-cycle proportional kick
    tag = "R8"; kp_v = 7;
    cyc(1, 0, 1);
    tag = "R3";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    // R4: late run at gain 2^-9, then early run at gain 2^-4
    tag = "R4";
    for (int i = 0; i < 600; i++) cyc(1, 0, 1);
    kp_v = 5; ki_v = 4;
    for (int i = 0; i < 80; i++) cyc(1, 1, 0);
    // R4: out-of-range shift behaves as 9
    ki_v = 13;
    for (int i = 0; i < 700; i++) cyc(1, 0, 1);
    // R2: both flags and neither flag with valid high
    tag = "R2"; kp_v = 2; ki_v = 6;
    for (int i = 0; i < 20; i++) cyc(1, 1, 1);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0);
    for (int i = 0; i < 30; i++) cyc(1, (i % 3) == 0, (i % 3) == 1);
    // R5: long burst gap holds the word
    tag = "R5";
    for (int i = 0; i < 500; i++) cyc(0, i[0], i[1]);
    // R6/R7: drive to positive saturation, word clamps at 255
    tag = "R6"; ki_v = 0; kp_v = 15; cal_v = 200;
    for (int i = 0; i < 300; i++) cyc(1, 0, 1);
    tag = "R7";
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    // R6/R7: negative saturation, word clamps at 0
    tag = "R6"; cal_v = 0;
    for (int i = 0; i < 600; i++) cyc(1, 1, 0);
    tag = "R7";
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    // R9: offset steps while idle, from the saturated low integrator
    tag = "R9";
    for (int i = 0; i < 6; i++) begin
      cal_v = 255 - 20 * i;
      cyc(0, 0, 0);
    end
    // R3/R7: small positive integral, early kick clamps at zero
    tag = "R3"; ki_v = 0; kp_v = 15; cal_v = 3;
    for (int i = 0; i < 260; i++) cyc(1, 0, 1);
    cyc(1, 1, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule